// File: doc/BRIEF.md
# Multimode Pulse Timer

This block is one channel of a 16-bit timer. A single up counter advances either on a prescaled clock enable (interval timer) or on rising edges of an external pin (event counter). Two comparators watch the counter. A match on the period register wraps the counter to zero. A match on the duty register, like a period match, toggles a timer flip-flop that drives the output pin, so the pair forms a programmable pulse generator. Each match also raises a one-cycle interrupt pulse.

The duty register can be double-buffered, so software can change the duty point mid-period without a glitch: the new value takes effect only at the next period wrap. The same external pin that clocks event counting also triggers capture. Its rising edge copies the counter into one capture register and its falling edge into the other, so software can measure pulse width as their difference, or frequency from successive captures. Registers are loaded through a simple one-cycle write strobe with a 2-bit address.

Top module: `pulse_timer`

## Requirements
- R1: After reset the count, both capture values, `timerOut`, `irqCmp0` and `irqCmp1` are all zero.
- R2: With run set and event mode clear, the count advances by one on every cycle that `tickEn` is high. The cycle after a control write that clears run (bit 0), the count reads zero, and it stays at zero while run is clear.
- R3: On an advance where the count equals the period register, the count becomes 0 instead of count+1. `irqCmp1` is high for exactly the following cycle.
- R4: On an advance where the count equals the active duty register, `irqCmp0` is high for the following cycle. A duty or period match toggles `timerOut`. When both match on the same advance, `timerOut` toggles only once.
- R5: With event mode (control bit 1) set, the count advances once per rising edge of `extIn`. `tickEn` has no effect.
- R6: With capture enabled (control bit 3), a rising edge of `extIn` stores the count value held in the cycle before the edge into `capRise`. A falling edge stores it into `capFall`. With capture disabled, both capture values stay unchanged.
- R7: With buffering clear, a write to address 1 sets the active duty value at once. With buffering set (control bit 2), the write goes to a buffer, and the buffer is copied to the active duty value on the next period wrap.
- R8: If a duty write and a period wrap fall in the same cycle while buffering is set, the wrap takes the buffer contents from before the write. The written value becomes active at the following wrap.
- R9: A write to address 3 loads `timerOut` from data bit 0. This write takes priority over a toggle in the same cycle.
- R10: The addresses are: 0 control {bit3 capture, bit2 buffer, bit1 event, bit0 run}, 1 duty compare, 2 period compare, 3 flip-flop load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaled count enable in timer mode |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| extIn | input | 1 | External event clock and capture trigger (synchronous) |
| timerOut | output | 1 | Timer flip-flop output |
| irqCmp0 | output | 1 | Duty match interrupt pulse |
| irqCmp1 | output | 1 | Period match interrupt pulse |
| count | output | 16 | Current counter value |
| capRise | output | 16 | Value captured on a rising edge of extIn |
| capFall | output | 16 | Value captured on a falling edge of extIn |

## Verification
Two pairs of events can land in the same cycle.

- **Duty match and period match.** Vectors with equal duty and period values make both comparators fire on the same advance. The checks require a single toggle per period and one pulse on each interrupt.
- **Buffered duty write and period reload.** The bench waits until the count sits on the period value and then issues the duty write in that very cycle. It judges which value became active by the count seen during the next two duty interrupts: the old buffered value must act for one period and the new value only in the period after that.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;
  // Register addresses; the control bit order is decoded by the control unit.
  localparam int REG_CTRL = 0;
  localparam int REG_DUTY = 1;
  localparam int REG_PER  = 2;
  localparam int REG_FF   = 3;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic adv;      // counter advances
    logic clr;      // counter forced to zero
    logic hit0;     // duty match on an advance
    logic hit1;     // period match on an advance
    logic reload;   // buffer copied to active duty
    logic capRise;  // capture into rising register
    logic capFall;  // capture into falling register
    logic bufEn;    // duty writes go to buffer only
    logic ld0;      // duty write
    logic ld1;      // period write
    logic ldFf;     // flip-flop load
  } strobe_t;
endpackage

// File: rtl/pulse_timer_ctrl.sv
module pulse_timer_ctrl
  import pulse_timer_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              extIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrBits,
  input  logic              eq0,
  input  logic              eq1,
  output strobe_t           st
);
  logic runQ, evtQ, bufQ, capQ, extQ;
  logic ldCtrl, rise, fall, stop, adv;

  assign ldCtrl = wrEn && (wrAddr == ADDR_W'(REG_CTRL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {capQ, bufQ, evtQ, runQ} <= '0;
      extQ <= 1'b0;
    end else begin
      if (ldCtrl) {capQ, bufQ, evtQ, runQ} <= wrBits;
      extQ <= extIn;
    end
  end

  assign rise = extIn & ~extQ;
  assign fall = ~extIn & extQ;
  assign stop = ~runQ | (ldCtrl & ~wrBits[0]);
  assign adv  = ~stop & (evtQ ? rise : tickEn);

  always_comb begin
    st         = '0;
    st.adv     = adv;
    st.clr     = stop;
    st.hit0    = adv & eq0;
    st.hit1    = adv & eq1;
    st.reload  = adv & eq1 & bufQ;
    st.capRise = capQ & rise;
    st.capFall = capQ & fall;
    st.bufEn   = bufQ;
    st.ld0     = wrEn && (wrAddr == ADDR_W'(REG_DUTY));
    st.ld1     = wrEn && (wrAddr == ADDR_W'(REG_PER));
    st.ldFf    = wrEn && (wrAddr == ADDR_W'(REG_FF));
  end

  // R5: in event mode an advance needs a rising edge seen at the pin.
  a_r5_event_edge: assert property (@(posedge clk) disable iff (!rstN)
    (evtQ && st.adv) |-> (extIn && !extQ));
endmodule

// File: rtl/pulse_timer_dp.sv
module pulse_timer_dp
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [CNT_W-1:0] wrData,
  output logic             eq0,
  output logic             eq1,
  output logic             ffQ,
  output logic             irq0,
  output logic             irq1,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] capR,
  output logic [CNT_W-1:0] capF
);
  localparam logic [CNT_W-1:0] CMP_RST = '1;

  logic [CNT_W-1:0] dutyBuf, dutyAct, period;

  assign eq0 = (cnt == dutyAct);
  assign eq1 = (cnt == period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dutyBuf <= CMP_RST;
      dutyAct <= CMP_RST;
      period  <= CMP_RST;
      ffQ     <= 1'b0;
      irq0    <= 1'b0;
      irq1    <= 1'b0;
      capR    <= '0;
      capF    <= '0;
    end else begin
      if (st.clr)       cnt <= '0;
      else if (st.hit1) cnt <= '0;
      else if (st.adv)  cnt <= cnt + 1'b1;

      if (st.ld0) dutyBuf <= wrData;
      if (st.ld0 && !st.bufEn) dutyAct <= wrData;
      else if (st.reload)      dutyAct <= dutyBuf;

      if (st.ld1) period <= wrData;

      if (st.ldFf)                 ffQ <= wrData[0];
      else if (st.hit0 || st.hit1) ffQ <= ~ffQ;

      irq0 <= st.hit0;
      irq1 <= st.hit1;

      if (st.capRise) capR <= cnt;
      if (st.capFall) capF <= cnt;
    end
  end

  a_r2_stop_clear: assert property (@(posedge clk) disable iff (!rstN)
    st.clr |=> (cnt == '0));
  a_r3_period_wrap: assert property (@(posedge clk) disable iff (!rstN)
    st.hit1 |=> (cnt == '0) && irq1);
  a_r4_ff_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!st.hit0 && !st.hit1 && !st.ldFf) |=> $stable(ffQ));
  a_r6_capture_rise: assert property (@(posedge clk) disable iff (!rstN)
    st.capRise |=> (capR == $past(cnt)));
  a_r7_duty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!st.reload && !(st.ld0 && !st.bufEn)) |=> $stable(dutyAct));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              extIn,
  output logic              timerOut,
  output logic              irqCmp0,
  output logic              irqCmp1,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capRise,
  output logic [CNT_W-1:0]  capFall
);
  strobe_t st;
  logic    eq0, eq1;

  pulse_timer_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn(extIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrBits(wrData[3:0]),
    .eq0(eq0), .eq1(eq1), .st(st)
  );

  pulse_timer_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .eq0(eq0), .eq1(eq1), .ffQ(timerOut), .irq0(irqCmp0), .irq1(irqCmp1),
    .cnt(count), .capR(capRise), .capF(capFall)
  );
endmodule

// File: tb/test_pulse_timer.sv
`timescale 1ns/1ps
module test_pulse_timer;
  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b1, wrEn = 1'b0, extIn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic timerOut, irqCmp0, irqCmp1;
  logic [15:0] count, capRise, capFall;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_timer i_pulse_timer (.*);

  // duty, period, advances
  localparam int VEC[6][3] = '{'{3, 9, 25}, '{0, 4, 12}, '{5, 5, 18},
                               '{7, 3, 10}, '{2, 2, 7}, '{1, 6, 30}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIrq0(output int c);
    c = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irqCmp0) begin c = int'(count); break; end
    end
  endtask

  task automatic waitCount(input int v);
    for (int k = 0; k < 40 && int'(count) != v; k++) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c, v, w, n0, n1, ec, ef, e0, e1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 timerOut", int'(timerOut), 0);
    chk("R1 irq", int'({irqCmp0, irqCmp1}), 0);
    chk("R1 captures", int'(capRise) + int'(capFall), 0);

    // R9/R10 flip-flop load at address 3
    wr(3, 1);
    chk("R9 ff load 1", int'(timerOut), 1);
    wr(3, 0);
    chk("R9 ff load 0", int'(timerOut), 0);

    // R2 R3 R4 vector table, timer mode
    foreach (VEC[i]) begin
      ec = 0; ef = 0; e0 = 0; e1 = 0;
      for (int k = 0; k < VEC[i][2]; k++) begin
        if (ec == VEC[i][0]) e0++;
        if (ec == VEC[i][1]) e1++;
        if (ec == VEC[i][0] || ec == VEC[i][1]) ef ^= 1;
        ec = (ec == VEC[i][1]) ? 0 : ec + 1;
      end
      wr(0, 0); wr(1, VEC[i][0]); wr(2, VEC[i][1]); wr(3, 0); wr(0, 1);
      n0 = 0; n1 = 0;
      for (int k = 0; k < VEC[i][2]; k++) begin
        @(negedge clk);
        if (irqCmp0) n0++;
        if (irqCmp1) n1++;
      end
      chk("R2 R3 count", int'(count), ec);
      chk("R4 timerOut", int'(timerOut), ef);
      chk("R4 irqCmp0 pulses", n0, e0);
      chk("R3 irqCmp1 pulses", n1, e1);
    end

    // R2 stop clears
    wr(0, 0); wr(0, 1);
    repeat (4) @(negedge clk);
    chk("R2 running count", int'(count), 4);
    wr(0, 0);
    chk("R2 stop clears", int'(count), 0);
    repeat (3) @(negedge clk);
    chk("R2 held at zero", int'(count), 0);

    // R7 R8 double buffer
    wr(1, 3); wr(2, 9); wr(0, 5);
    wr(1, 6);
    waitIrq0(c); chk("R7 old duty still active", c, 4);
    waitIrq0(c); chk("R7 buffer moved at wrap", c, 7);
    waitCount(9);
    wr(1, 2);
    waitIrq0(c); chk("R8 wrap took old buffer", c, 7);
    waitIrq0(c); chk("R8 new value next wrap", c, 3);

    // R5 event counting, tickEn ignored (held high)
    wr(0, 0); wr(2, 100); wr(0, 3);
    for (int k = 0; k < 5; k++) begin
      extIn = 1'b1; repeat (2) @(negedge clk);
      extIn = 1'b0; repeat (3) @(negedge clk);
    end
    chk("R5 event count", int'(count), 5);

    // R6 capture
    wr(0, 0); wr(2, 1000); wr(0, 9);
    repeat (5) @(negedge clk);
    v = int'(count); extIn = 1'b1;
    repeat (7) @(negedge clk);
    w = int'(count); extIn = 1'b0;
    @(negedge clk);
    chk("R6 rising capture", int'(capRise), v);
    chk("R6 falling capture", int'(capFall), w);
    chk("R6 width", int'(capFall) - int'(capRise), 7);
    wr(0, 1);
    extIn = 1'b1; repeat (3) @(negedge clk);
    extIn = 1'b0; repeat (3) @(negedge clk);
    chk("R6 disabled rise", int'(capRise), v);
    chk("R6 disabled fall", int'(capFall), w);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule